// File: doc/BRIEF.md
# Receive Loss-of-Signal Monitor with Data Gating

This block watches a recovered receive bit stream, one bit per cycle in which `bit_en` is high, and keeps a loss-of-signal alarm. The alarm goes up on a long run of zeros or at once when an external analog detector reports a low line level. It comes down only after the stream passes a ones-density check: a block window of bits must hold enough marks, and no zero run inside it may grow past a limit. A zero-run counter is shared between setting the alarm and qualifying the window. Reset and channel power-down force the alarm on.

The same block decides what reaches the receive data outputs. During the alarm both rails are squelched to zero. With automatic fill enabled, an unframed all-ones pattern is sent instead. Digital loopback bypasses all gating. Setting both loopback control bits forces all ones whatever the alarm state. A sticky copy of the alarm is kept for status polling.

A three-state machine holds the alarm. DOWN is entered from any state while `pwr_down` is high and is left for HUNT on the first cycle without it. HUNT is the alarm state and the reset state; it moves to LIVE when a qualifying window completes and passes. LIVE is the no-alarm state; it returns to HUNT when `low_level` is high or when a zero bit makes the run reach `SET_ZEROS`.

Top module: `los_monitor`

## Requirements
- R1: While `rst_n` is low, `los_pin` and `los_latched` are 1 and both data outputs are 0. A cycle with `pwr_down` high puts the block in DOWN, clears the zero run, and makes `los_pin` 1 after that edge.
- R2: A bit is a mark when `rx_pos|rx_neg` is 1 in dual-rail mode (`nrz_mode`=0). In LIVE, the edge at which the zero run reaches `SET_ZEROS` consecutive zero bits moves the block to HUNT, so `los_pin` is 1 after that edge. A mark resets the run to 0.
- R3: `low_level` high in any cycle makes `los_pin` 1 after that edge. While `low_level` stays high, the qualifying window is held empty.
- R4: In HUNT, qualifying bits fill a block window of `WIN_LEN` bits. If the window's last bit brings its mark count to at least `MIN_ONES`, `los_pin` is 0 after that edge. `los_pin` falls by no other route.
- R5: A window that completes with fewer than `MIN_ONES` marks leaves `los_pin` at 1. A fresh window starts with the next bit.
- R6: A zero bit that takes the run above `MAX_RUN` empties the window. Counting restarts with the next mark, which is the first bit of the new window.
- R7: On a `bit_en` cycle in which the alarm is up and no override applies, both outputs are 0 after the edge.
- R8: With `dig_loop`=1, and without the forced-ones override, the outputs copy `rx_pos` and `rx_neg` of that `bit_en` cycle whatever the alarm state.
- R9: With `auto_ones`=1 and the alarm up, each `bit_en` cycle outputs a mark. In dual-rail mode the marks alternate rails: the first after reset is on `out_pos`, the next on `out_neg`, and so on. In single-rail mode (`nrz_mode`=1), `out_pos`=1 and `out_neg`=0.
- R10: With `loop_a` and `loop_b` both 1, every `bit_en` cycle outputs an all-ones mark, encoded as in R9, whatever the alarm state and `dig_loop`.
- R11: `los_latched` becomes 1 on the edge after any cycle with the alarm up. It clears only through a `sticky_clr` cycle in which the alarm is down, and setting wins over clearing.
- R12: In single-rail mode only `rx_pos` counts as a mark. Cycles with `bit_en`=0 change neither the zero run, the window, nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One received bit is present this cycle |
| rx_pos | input | 1 | Positive rail, or data in single-rail mode |
| rx_neg | input | 1 | Negative rail |
| nrz_mode | input | 1 | 1 = single-rail data on `rx_pos` |
| low_level | input | 1 | Analog low-signal indication |
| pwr_down | input | 1 | Channel power-down |
| dig_loop | input | 1 | Digital loopback, disables gating |
| auto_ones | input | 1 | Send all ones instead of zeros during the alarm |
| loop_a | input | 1 | Loopback control bit A |
| loop_b | input | 1 | Loopback control bit B; both high forces all ones |
| sticky_clr | input | 1 | Clear request for the latched alarm |
| los_pin | output | 1 | Live alarm level |
| los_latched | output | 1 | Sticky alarm bit |
| out_pos | output | 1 | Gated positive rail / data |
| out_neg | output | 1 | Gated negative rail |

## Verification
The bench builds the block with `SET_ZEROS`=8, `WIN_LEN`=8, `MIN_ONES`=2 and `MAX_RUN`=4. At these values every one of the 256 possible contents of a first window can be fed after a power-down. The bench predicts the clear decision from the mark count and the longest zero run alone, which reaches both the density threshold and the run-abort edge exactly. The short alarm threshold lets the set path, every output-gating mode and both rail encodings run many times over. A bit-level model in the bench checks every output on every cycle.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic [1:0] {
        LS_DOWN = 2'd0,
        LS_HUNT = 2'd1,
        LS_LIVE = 2'd2
    } los_state_t;

    typedef enum logic [1:0] {
        FILL_PASS = 2'd0,
        FILL_ZERO = 2'd1,
        FILL_ONES = 2'd2
    } fill_t;

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
    parameter int SET_ZEROS = 175,
    parameter int MAX_RUN   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic bit_en,
    input  logic mark,
    output logic run_hit,
    output logic run_over
);
    localparam int RW = $clog2(SET_ZEROS + 1);
    localparam logic [RW-1:0] SAT  = RW'(SET_ZEROS);
    localparam logic [RW-1:0] MAXR = RW'(MAX_RUN);

    logic [RW-1:0] run_q;
    logic [RW-1:0] run_nx;

    always_comb begin
        if (mark) begin
            run_nx = '0;
        end else if (run_q == SAT) begin
            run_nx = run_q;
        end else begin
            run_nx = run_q + 1'b1;
        end
    end

    assign run_hit  = bit_en && (run_nx == SAT);
    assign run_over = bit_en && (run_nx > MAXR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pwr_down) begin
            run_q <= '0;
        end else if (bit_en) begin
            run_q <= run_nx;
        end
    end

    // R2: a mark empties the run
    assert_mark_clears_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && mark) |=> (run_q == '0));

    // R12: idle cycles leave the run alone
    assert_idle_holds_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !pwr_down) |=> $stable(run_q));

endmodule

// File: rtl/los_window.sv
module los_window #(
    parameter int WIN_LEN  = 175,
    parameter int MIN_ONES = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_en,
    input  logic mark,
    input  logic abort,
    output logic done,
    output logic pass
);
    localparam int PW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int OW = $clog2(WIN_LEN + 1);
    localparam logic [PW-1:0] LASTP = PW'(WIN_LEN - 1);
    localparam logic [OW-1:0] MINV  = OW'(MIN_ONES);

    logic [PW-1:0] pos_q;
    logic [OW-1:0] ones_q;
    logic [OW-1:0] ones_nx;
    logic          take;
    logic          last;

    assign ones_nx = ones_q + {{(OW-1){1'b0}}, mark};
    assign take    = bit_en && !clr && !abort;
    assign last    = (pos_q == LASTP);
    assign done    = take && last;
    assign pass    = (ones_nx >= MINV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            ones_q <= '0;
        end else if (clr || (bit_en && abort)) begin
            pos_q  <= '0;
            ones_q <= '0;
        end else if (take) begin
            if (last) begin
                pos_q  <= '0;
                ones_q <= '0;
            end else begin
                pos_q  <= pos_q + 1'b1;
                ones_q <= ones_nx;
            end
        end
    end

    // R6: a run abort empties the window
    assert_abort_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && abort) |=> (pos_q == '0 && ones_q == '0));

    // R3: held empty while cleared
    assert_clr_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pos_q == '0));

endmodule

// File: rtl/los_out_gate.sv
module los_out_gate
    import los_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic los,
    input  logic nrz_mode,
    input  logic dig_loop,
    input  logic auto_ones,
    input  logic force_ones,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic out_pos,
    output logic out_neg
);
    fill_t sel;
    logic  phase_q;
    logic  pos_nx;
    logic  neg_nx;

    always_comb begin
        if (force_ones) begin
            sel = FILL_ONES;
        end else if (dig_loop) begin
            sel = FILL_PASS;
        end else if (los && auto_ones) begin
            sel = FILL_ONES;
        end else if (los) begin
            sel = FILL_ZERO;
        end else begin
            sel = FILL_PASS;
        end
    end

    always_comb begin
        unique case (sel)
            FILL_PASS: begin
                pos_nx = rx_pos;
                neg_nx = rx_neg;
            end
            FILL_ZERO: begin
                pos_nx = 1'b0;
                neg_nx = 1'b0;
            end
            FILL_ONES: begin
                pos_nx = nrz_mode ? 1'b1 : !phase_q;
                neg_nx = nrz_mode ? 1'b0 : phase_q;
            end
            default: begin
                pos_nx = 1'b0;
                neg_nx = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pos <= 1'b0;
            out_neg <= 1'b0;
            phase_q <= 1'b0;
        end else if (bit_en) begin
            out_pos <= pos_nx;
            out_neg <= neg_nx;
            if (sel == FILL_ONES && !nrz_mode) begin
                phase_q <= !phase_q;
            end
        end
    end

    // R7: squelch during the alarm
    assert_squelch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && los && !force_ones && !dig_loop && !auto_ones) |=> (!out_pos && !out_neg));

    // R8: loopback passes data
    assert_loop_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && dig_loop && !force_ones) |=> (out_pos == $past(rx_pos) && out_neg == $past(rx_neg)));

    // R10: forced ones give exactly one mark
    assert_force_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && force_ones) |=> $countones({out_pos, out_neg}) == 1);

    // R12: idle cycles hold the outputs
    assert_idle_outputs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(out_pos) && $stable(out_neg)));

endmodule

// File: rtl/los_monitor.sv
module los_monitor
    import los_pkg::*;
#(
    parameter int SET_ZEROS = 175,
    parameter int WIN_LEN   = 175,
    parameter int MIN_ONES  = 22,
    parameter int MAX_RUN   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic nrz_mode,
    input  logic low_level,
    input  logic pwr_down,
    input  logic dig_loop,
    input  logic auto_ones,
    input  logic loop_a,
    input  logic loop_b,
    input  logic sticky_clr,
    output logic los_pin,
    output logic los_latched,
    output logic out_pos,
    output logic out_neg
);
    los_state_t state_q;
    los_state_t state_nx;
    logic       mark;
    logic       run_hit;
    logic       run_over;
    logic       win_clr;
    logic       win_done;
    logic       win_pass;
    logic       alarm;

    // R2 / R12: mark definition depends on rail mode
    assign mark    = nrz_mode ? rx_pos : (rx_pos | rx_neg);
    assign win_clr = (state_q != LS_HUNT) || low_level || pwr_down;

    los_zero_run #(
        .SET_ZEROS (SET_ZEROS),
        .MAX_RUN   (MAX_RUN)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .bit_en   (bit_en),
        .mark     (mark),
        .run_hit  (run_hit),
        .run_over (run_over)
    );

    los_window #(
        .WIN_LEN  (WIN_LEN),
        .MIN_ONES (MIN_ONES)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_clr),
        .bit_en (bit_en),
        .mark   (mark),
        .abort  (run_over),
        .done   (win_done),
        .pass   (win_pass)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (pwr_down) begin
            state_nx = LS_DOWN;
        end else begin
            unique case (state_q)
                LS_DOWN: state_nx = LS_HUNT;
                LS_HUNT: if (win_done && win_pass) state_nx = LS_LIVE;
                LS_LIVE: if (low_level || run_hit) state_nx = LS_HUNT;
                default: state_nx = LS_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_HUNT;
        end else begin
            state_q <= state_nx;
        end
    end

    // alarm outputs
    assign alarm   = (state_q != LS_LIVE);
    assign los_pin = alarm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            los_latched <= 1'b1;
        end else begin
            los_latched <= alarm | (los_latched & ~sticky_clr);
        end
    end

    los_out_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .los        (alarm),
        .nrz_mode   (nrz_mode),
        .dig_loop   (dig_loop),
        .auto_ones  (auto_ones),
        .force_ones (loop_a & loop_b),
        .rx_pos     (rx_pos),
        .rx_neg     (rx_neg),
        .out_pos    (out_pos),
        .out_neg    (out_neg)
    );

    assert_powerdown_alarm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> los_pin);

    assert_zero_run_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_hit |=> los_pin);

    assert_low_level_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        low_level |=> los_pin);

    assert_clear_by_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_pin) |-> $past(win_done && win_pass));

    assert_sticky_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        los_pin |=> los_latched);

endmodule

// File: tb/los_monitor_bench.sv
module los_monitor_bench;
    localparam int SETZ = 8;
    localparam int WIN  = 8;
    localparam int MINO = 2;
    localparam int MAXR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0, nrz_mode = 1'b0;
    logic low_level = 1'b0, pwr_down = 1'b0, dig_loop = 1'b0, auto_ones = 1'b0;
    logic loop_a = 1'b0, loop_b = 1'b0, sticky_clr = 1'b0;
    logic los_pin, los_latched, out_pos, out_neg;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model state: 0 down, 1 hunt, 2 live
    int m_state = 1, m_run = 0, m_pos = 0, m_ones = 0;
    bit m_phase = 1'b0, m_opos = 1'b0, m_oneg = 1'b0, m_sticky = 1'b1;

    always #2.5 clk = ~clk;

    los_monitor #(
        .SET_ZEROS (SETZ),
        .WIN_LEN   (WIN),
        .MIN_ONES  (MINO),
        .MAX_RUN   (MAXR)
    ) u_los_monitor (
        .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .rx_pos (rx_pos), .rx_neg (rx_neg),
        .nrz_mode (nrz_mode), .low_level (low_level), .pwr_down (pwr_down),
        .dig_loop (dig_loop), .auto_ones (auto_ones), .loop_a (loop_a), .loop_b (loop_b),
        .sticky_clr (sticky_clr), .los_pin (los_pin), .los_latched (los_latched),
        .out_pos (out_pos), .out_neg (out_neg)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit mk, alarm, clr, done, pass;
        int run_nx, ones_n;
        bit fo;
        mk    = nrz_mode ? rx_pos : (rx_pos | rx_neg);
        alarm = (m_state != 2);
        fo    = loop_a & loop_b;
        if (bit_en) begin
            if (fo || (!dig_loop && alarm && auto_ones)) begin
                m_opos = nrz_mode ? 1'b1 : !m_phase;
                m_oneg = nrz_mode ? 1'b0 : m_phase;
                if (!nrz_mode) m_phase = !m_phase;
            end else if (!dig_loop && alarm) begin
                m_opos = 1'b0; m_oneg = 1'b0;
            end else begin
                m_opos = rx_pos; m_oneg = rx_neg;
            end
        end
        m_sticky = alarm | (m_sticky & !sticky_clr);
        run_nx = mk ? 0 : ((m_run + 1 > SETZ) ? SETZ : m_run + 1);
        done = 1'b0; pass = 1'b0;
        clr = (m_state != 1) || low_level || pwr_down;
        if (clr) begin
            m_pos = 0; m_ones = 0;
        end else if (bit_en) begin
            if (run_nx > MAXR) begin
                m_pos = 0; m_ones = 0;
            end else begin
                ones_n = m_ones + int'(mk);
                if (m_pos == WIN - 1) begin
                    done = 1'b1; pass = (ones_n >= MINO);
                    m_pos = 0; m_ones = 0;
                end else begin
                    m_pos++; m_ones = ones_n;
                end
            end
        end
        if (pwr_down) m_run = 0;
        else if (bit_en) m_run = run_nx;
        if (pwr_down) m_state = 0;
        else if (m_state == 0) m_state = 1;
        else if (m_state == 1) begin
            if (done && pass) m_state = 2;
        end else if (low_level || (bit_en && run_nx == SETZ)) m_state = 1;
    endtask

    // one clock; inputs already set; compare all outputs with the model
    task automatic step(input logic en, input logic p, input logic n, input string tag);
        bit_en = en; rx_pos = p; rx_neg = n;
        @(posedge clk);
        #1;
        model_edge();
        check({tag, " los_pin"}, int'(los_pin), int'(m_state != 2));
        check("R11 los_latched", int'(los_latched), int'(m_sticky));
        check({tag, " out_pos"}, int'(out_pos), int'(m_opos));
        check({tag, " out_neg"}, int'(out_neg), int'(m_oneg));
    endtask

    task automatic marks(input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) step(1'b1, i[0] == 1'b0, i[0] == 1'b1, tag);
    endtask

    task automatic zeros(input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) step(1'b1, 1'b0, 1'b0, tag);
    endtask

    function automatic bit clears(input logic [7:0] p);
        int run = 0;
        int worst = 0;
        for (int i = 0; i < 8; i++) begin
            run = p[i] ? 0 : run + 1;
            if (run > worst) worst = run;
        end
        return ($countones(p) >= MINO) && (worst <= MAXR);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int prev;
        #12;
        // R1: reset state
        check("R1 los in reset", int'(los_pin), 1);
        check("R1 sticky in reset", int'(los_latched), 1);
        check("R1 outputs in reset", int'({out_pos, out_neg}), 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R4: first window of marks clears
        marks(WIN, "R4");
        check("R4 cleared after window", int'(los_pin), 0);
        sticky_clr = 1'b1; step(1'b0, 1'b0, 1'b0, "R11"); sticky_clr = 1'b0;
        check("R11 sticky cleared", int'(los_latched), 0);

        // R2: zero run sets alarm exactly at SETZ
        zeros(SETZ - 1, "R2");
        check("R2 below threshold", int'(los_pin), 0);
        zeros(1, "R2");
        check("R2 at threshold", int'(los_pin), 1);
        step(1'b0, 1'b0, 1'b0, "R11");
        check("R11 sticky set", int'(los_latched), 1);

        // R7: squelch in alarm
        step(1'b1, 1'b1, 1'b0, "R7");
        check("R7 squelched", int'({out_pos, out_neg}), 0);

        // R9: auto ones dual-rail alternates
        auto_ones = 1'b1;
        step(1'b1, 1'b0, 1'b0, "R9");
        prev = int'({out_pos, out_neg});
        check("R9 one mark", $countones({out_pos, out_neg}), 1);
        step(1'b1, 1'b0, 1'b0, "R9");
        check("R9 alternates", int'({out_pos, out_neg}), 3 - prev);
        nrz_mode = 1'b1;
        step(1'b1, 1'b0, 1'b1, "R9");
        check("R9 single-rail ones", int'({out_pos, out_neg}), 2);
        nrz_mode = 1'b0; auto_ones = 1'b0;

        // R8: loopback passes during alarm
        dig_loop = 1'b1;
        step(1'b1, 1'b0, 1'b1, "R8");
        check("R8 passthrough", int'({out_pos, out_neg}), 1);
        step(1'b1, 1'b1, 1'b0, "R8");
        dig_loop = 1'b0;

        // back to LIVE, then R10 forced ones in both states
        marks(1, "R6"); marks(WIN, "R4");
        check("R4 cleared again", int'(los_pin), 0);
        loop_a = 1'b1; loop_b = 1'b1; dig_loop = 1'b1;
        step(1'b1, 1'b0, 1'b0, "R10");
        check("R10 forced in live", $countones({out_pos, out_neg}), 1);
        dig_loop = 1'b0;
        step(1'b1, 1'b1, 1'b1, "R10");
        loop_b = 1'b0;
        step(1'b1, 1'b1, 1'b0, "R10");
        check("R10 one bit is not enough", int'({out_pos, out_neg}), 2);
        loop_a = 1'b0;

        // R3: low level sets and holds window empty
        low_level = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R3");
        check("R3 low level sets", int'(los_pin), 1);
        marks(WIN + 2, "R3");
        check("R3 held while low", int'(los_pin), 1);
        low_level = 1'b0;
        marks(WIN, "R4");

        // R12: idle cycles and single-rail marks
        for (int i = 0; i < SETZ + 3; i++) step(1'b0, 1'b0, 1'b0, "R12");
        check("R12 idle keeps live", int'(los_pin), 0);
        nrz_mode = 1'b1;
        for (int i = 0; i < SETZ; i++) step(1'b1, 1'b0, 1'b1, "R12");
        check("R12 neg rail not a mark", int'(los_pin), 1);
        for (int i = 0; i < WIN; i++) step(1'b1, 1'b1, 1'b0, "R12");
        check("R12 pos rail marks clear", int'(los_pin), 0);
        nrz_mode = 1'b0;

        // R1: power-down
        pwr_down = 1'b1; step(1'b1, 1'b1, 1'b0, "R1");
        check("R1 power-down alarm", int'(los_pin), 1);

        // R4/R5/R6: every first-window pattern after power-down
        for (int p = 0; p < 256; p++) begin
            logic [7:0] v;
            bit exp_clear;
            string tg;
            v = p[7:0];
            pwr_down = 1'b1; step(1'b0, 1'b0, 1'b0, "R1");
            pwr_down = 1'b0; step(1'b0, 1'b0, 1'b0, "R1");
            for (int i = 0; i < 8; i++) step(1'b1, v[i] & ~i[0], v[i] & i[0], "R4");
            exp_clear = clears(v);
            if ($countones(v) < MINO) tg = "R5 sweep";
            else if (!exp_clear) tg = "R6 sweep";
            else tg = "R4 sweep";
            check(tg, int'(los_pin), int'(!exp_clear));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule